// File: doc/BRIEF.md
# Smart-Card Half-Duplex Serial Transceiver with Error Echo

This block is a character-framed serial transceiver for one shared, wired-AND data line, such as the link to a subscriber or payment card. The transmit output and the receive input are joined outside the chip, so the line that the block observes is the AND of its own output and whatever the far end drives. A character is a low start bit, eight data bits, an even-parity bit and a high stop bit. Each bit lasts 16 × (n + 1) clock cycles, where n is the value on the divider input.

On receive, a parity failure is reported to the sender in the same character. The receiver pulls its output low for the whole stop-bit slot, and a transmitter that samples the line in the middle of that slot sees the low level and latches an error-echo status. A write-once transmit buffer feeds the transmit shift register. A receive buffer with a full flag holds each completed character. Two interrupt request flags stay set until they are cleared. A format input selects one of two bit orders: direct (least significant bit first, true levels) or inverse (most significant bit first, inverted levels).

Top module: `sc_halfduplex_uart`

## Requirements
- R1: The output idles high. A character on the output is the start bit (0), then eight data bits, then the parity bit, then the stop bit (1). Slot j (0 = start, 10 = stop) starts in the cycle after the transmit shift register loads, plus j bit periods.
- R2: The parity bit is chosen so that the line levels of the eight data slots plus the parity slot hold an even number of ones.
- R3: With invFormat = 0, data slot i carries data bit i at its true level. With invFormat = 1, data slot i carries the inverse of data bit 7 − i. The receiver decodes rdData by the same rule.
- R4: Every slot lasts exactly 16 × (divVal + 1) clock cycles.
- R5: txBufEmpty goes low on the edge that takes a write. It goes high on the next edge, when the byte moves into the shift register, provided the transmitter is idle and enabled.
- R6: txRegEmpty and txIrq go high on the edge that closes the stop slot. txIrq then stays high until a cycle with txIrqClr high.
- R7: Once the receiver has a character, rxFull and rxIrq go high and rdData holds the decoded byte. rdStrobe clears rxFull only, and rxIrqClr clears rxIrq only.
- R8: If the received parity check fails, txOut is held low throughout the receiver's stop slot, and rxParErr is 1 for that character. Otherwise txOut stays high and rxParErr is 0.
- R9: errSeen goes high if the line is low at the middle of the transmitter's stop slot. It stays high until the next character loads.
- R10: No character starts while txEnable is low. Clearing txEnable mid-character returns the output high at once, with no txIrq. While rxEnable is low the line is ignored, and clearing it mid-character discards that character.
- R11: A low pulse shorter than half a bit period on an idle line does not start a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the bit-rate count source |
| rst_n | input | 1 | Active-low asynchronous reset |
| divVal | input | 8 | Divider value n; bit period 16 × (n + 1) cycles |
| txEnable | input | 1 | Transmitter enable; low aborts and holds idle |
| rxEnable | input | 1 | Receiver enable; low aborts and holds idle |
| invFormat | input | 1 | 0 direct (LSB first, true levels), 1 inverse (MSB first, inverted) |
| wrStrobe | input | 1 | Write wrData into the transmit buffer |
| wrData | input | 8 | Byte to transmit |
| rdStrobe | input | 1 | Read acknowledge; clears rxFull |
| rdData | output | 8 | Last received, decoded byte |
| txIrqClr | input | 1 | Clears the transmit interrupt request |
| rxIrqClr | input | 1 | Clears the receive interrupt request |
| lineIn | input | 1 | Level of the shared line |
| txOut | output | 1 | Open-drain style drive toward the shared line (0 pulls low) |
| txBufEmpty | output | 1 | Transmit buffer can take a byte |
| txRegEmpty | output | 1 | Transmit shift register is idle |
| txIrq | output | 1 | Transmit-complete interrupt request |
| rxFull | output | 1 | Receive buffer holds an unread character |
| rxIrq | output | 1 | Receive-complete interrupt request |
| rxParErr | output | 1 | Parity failed on the buffered character |
| errSeen | output | 1 | Error echo detected in the last transmitted stop slot |

## Verification
The bench sweeps data bytes, both bit orders and three divider values. It checks each slot at its centre and on both sides of each slot boundary, so a divider off by one cycle, or a bit order or inversion taken from the wrong end, shows up as a wrong level in a named slot. On receive it corrupts the parity bit and checks that the low echo covers the stop slot and nothing earlier; a receiver that checked odd parity, or drove the echo one slot early, would pull the parity slot low or stay silent. It also goes after disable in mid-character, a short glitch on an idle line, and a card that pulls the stop slot low. In these cases a faulty design would finish a character it was told to abandon, start receiving on noise, or miss the echo.

// File: rtl/sc_uart_pkg.sv
package sc_uart_pkg;

  typedef enum logic {TX_IDLE, TX_SEND} txState_e;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rxState_e;

  // Strobes from control to datapath, one cycle each unless noted
  typedef struct packed {
    logic txLoad;    // move buffer into the frame shift register
    logic txShift;   // advance to the next slot
    logic txAbort;   // level: force the frame register to idle ones
    logic txFinish;  // stop slot has ended
    logic txProbe;   // middle of the transmit stop slot
    logic rxClear;   // start edge accepted
    logic rxSample;  // middle of a data or parity slot
    logic rxFinish;  // receive stop slot has ended
    logic rxErrSlot; // level: receiver is inside its stop slot
  } ctlStrobe_t;

endpackage

// File: rtl/sc_uart_bittimer.sv
module sc_uart_bittimer #(
  parameter int DIV_W    = 8,
  parameter int SUBTICKS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divVal,
  output logic             midTick,
  output logic             endTick
);
  localparam int CNT_W = DIV_W + $clog2(SUBTICKS) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] periodM1;
  logic [CNT_W-1:0] halfM1;

  always_comb begin
    periodM1 = CNT_W'(SUBTICKS) * (CNT_W'(divVal) + CNT_W'(1)) - CNT_W'(1);
    halfM1   = periodM1 >> 1;
    midTick  = run && (cnt == halfM1);
    endTick  = run && (cnt >= periodM1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || endTick)  cnt <= '0;
    else                       cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/sc_uart_ctrl.sv
module sc_uart_ctrl
  import sc_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txEnable,
  input  logic       rxEnable,
  input  logic       txBufFull,
  input  logic       lineS,
  input  logic       lineFell,
  input  logic       txMid,
  input  logic       txEnd,
  input  logic       rxMid,
  input  logic       rxEnd,
  output ctlStrobe_t st,
  output logic       txRun,
  output logic       rxRun
);
  localparam int FRAME_BITS = DATA_W + 3;
  localparam int TXI_W      = $clog2(FRAME_BITS);
  localparam int RXI_W      = $clog2(DATA_W + 2);
  localparam logic [TXI_W-1:0] TX_LAST = TXI_W'(FRAME_BITS - 1);
  localparam logic [RXI_W-1:0] RX_LAST = RXI_W'(DATA_W);

  txState_e         txState;
  rxState_e         rxState;
  logic [TXI_W-1:0] txIdx;
  logic [RXI_W-1:0] rxIdx;

  assign txRun = (txState == TX_SEND);
  assign rxRun = (rxState != RX_IDLE);

  always_comb begin
    st = '0;
    if (!txEnable) begin
      st.txAbort = 1'b1;
    end else if (txState == TX_IDLE) begin
      st.txLoad = txBufFull;
    end else begin
      st.txProbe = txMid && (txIdx == TX_LAST);
      if (txEnd) begin
        if (txIdx == TX_LAST) st.txFinish = 1'b1;
        else                  st.txShift  = 1'b1;
      end
    end
    st.rxClear   = rxEnable && (rxState == RX_IDLE) && lineFell;
    st.rxSample  = (rxState == RX_BITS) && rxMid;
    st.rxFinish  = (rxState == RX_STOP) && rxEnd;
    st.rxErrSlot = (rxState == RX_STOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txState <= TX_IDLE;
      txIdx   <= '0;
    end else if (!txEnable) begin
      txState <= TX_IDLE;
      txIdx   <= '0;
    end else if (txState == TX_IDLE) begin
      if (txBufFull) begin
        txState <= TX_SEND;
        txIdx   <= '0;
      end
    end else if (txEnd) begin
      if (txIdx == TX_LAST) txState <= TX_IDLE;
      else                  txIdx   <= txIdx + TXI_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxState <= RX_IDLE;
      rxIdx   <= '0;
    end else if (!rxEnable) begin
      rxState <= RX_IDLE;
      rxIdx   <= '0;
    end else begin
      case (rxState)
        RX_IDLE:  if (lineFell) rxState <= RX_START;
        RX_START: begin
          if (rxMid && lineS) rxState <= RX_IDLE;
          else if (rxEnd) begin
            rxState <= RX_BITS;
            rxIdx   <= '0;
          end
        end
        RX_BITS:  if (rxEnd) begin
          if (rxIdx == RX_LAST) rxState <= RX_STOP;
          else                  rxIdx   <= rxIdx + RXI_W'(1);
        end
        default:  if (rxEnd) rxState <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sc_uart_datapath.sv
module sc_uart_datapath
  import sc_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        st,
  input  logic              invFormat,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStrobe,
  input  logic              txIrqClr,
  input  logic              rxIrqClr,
  input  logic              lineIn,
  output logic              lineS,
  output logic              lineFell,
  output logic              txBufFull,
  output logic              txIrq,
  output logic              rxFull,
  output logic              rxIrq,
  output logic [DATA_W-1:0] rxData,
  output logic              rxParErr,
  output logic              errSeen,
  output logic              txOut
);
  localparam int FRAME_BITS = DATA_W + 3;

  logic [2:0]            lineSync;
  logic [DATA_W-1:0]     txBuf;
  logic [DATA_W-1:0]     txLevels;
  logic [FRAME_BITS-1:0] txSh;
  logic [DATA_W:0]       rxSh;
  logic [DATA_W-1:0]     rxDecoded;
  logic                  rxOdd;

  assign lineS    = lineSync[1];
  assign lineFell = lineSync[2] & ~lineSync[1];
  assign rxOdd    = ^rxSh;
  assign txOut    = txSh[0] & ~(st.rxErrSlot & rxOdd);

  // Line level of each data slot, and decode of received slot levels
  for (genvar i = 0; i < DATA_W; i++) begin : g_order
    assign txLevels[i]  = invFormat ? ~txBuf[DATA_W-1-i] : txBuf[i];
    assign rxDecoded[i] = invFormat ? ~rxSh[DATA_W-1-i]  : rxSh[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lineSync <= '1;
    else        lineSync <= {lineSync[1:0], lineIn};
  end

  // Transmit side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txBuf     <= '0;
      txBufFull <= 1'b0;
      txSh      <= '1;
      txIrq     <= 1'b0;
      errSeen   <= 1'b0;
    end else begin
      if (wrStrobe) begin
        txBuf     <= wrData;
        txBufFull <= 1'b1;
      end else if (st.txLoad) begin
        txBufFull <= 1'b0;
      end

      if (st.txAbort)      txSh <= '1;
      else if (st.txLoad)  txSh <= {1'b1, ^txLevels, txLevels, 1'b0};
      else if (st.txShift) txSh <= {1'b1, txSh[FRAME_BITS-1:1]};

      if (st.txFinish)     txIrq <= 1'b1;
      else if (txIrqClr)   txIrq <= 1'b0;

      if (st.txLoad)                  errSeen <= 1'b0;
      else if (st.txProbe && !lineS)  errSeen <= 1'b1;
    end
  end

  // Receive side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxSh     <= '0;
      rxData   <= '0;
      rxFull   <= 1'b0;
      rxIrq    <= 1'b0;
      rxParErr <= 1'b0;
    end else begin
      if (st.rxClear)       rxSh <= '0;
      else if (st.rxSample) rxSh <= {lineS, rxSh[DATA_W:1]};

      if (st.rxFinish) begin
        rxData   <= rxDecoded;
        rxParErr <= rxOdd;
        rxFull   <= 1'b1;
      end else if (rdStrobe) begin
        rxFull   <= 1'b0;
      end

      if (st.rxFinish)    rxIrq <= 1'b1;
      else if (rxIrqClr)  rxIrq <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_halfduplex_uart.sv
module sc_halfduplex_uart
  import sc_uart_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DATA_W   = 8,
  parameter int SUBTICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divVal,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic              invFormat,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStrobe,
  output logic [DATA_W-1:0] rdData,
  input  logic              txIrqClr,
  input  logic              rxIrqClr,
  input  logic              lineIn,
  output logic              txOut,
  output logic              txBufEmpty,
  output logic              txRegEmpty,
  output logic              txIrq,
  output logic              rxFull,
  output logic              rxIrq,
  output logic              rxParErr,
  output logic              errSeen
);
  ctlStrobe_t st;
  logic txRun, rxRun, txMid, txEnd, rxMid, rxEnd;
  logic lineS, lineFell, txBufFull;

  sc_uart_bittimer #(.DIV_W(DIV_W), .SUBTICKS(SUBTICKS)) u_txTimer (
    .clk(clk), .rst_n(rst_n), .run(txRun), .divVal(divVal),
    .midTick(txMid), .endTick(txEnd));

  sc_uart_bittimer #(.DIV_W(DIV_W), .SUBTICKS(SUBTICKS)) u_rxTimer (
    .clk(clk), .rst_n(rst_n), .run(rxRun), .divVal(divVal),
    .midTick(rxMid), .endTick(rxEnd));

  sc_uart_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .txEnable(txEnable), .rxEnable(rxEnable),
    .txBufFull(txBufFull), .lineS(lineS), .lineFell(lineFell),
    .txMid(txMid), .txEnd(txEnd), .rxMid(rxMid), .rxEnd(rxEnd),
    .st(st), .txRun(txRun), .rxRun(rxRun));

  sc_uart_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .invFormat(invFormat),
    .wrStrobe(wrStrobe), .wrData(wrData), .rdStrobe(rdStrobe),
    .txIrqClr(txIrqClr), .rxIrqClr(rxIrqClr), .lineIn(lineIn),
    .lineS(lineS), .lineFell(lineFell), .txBufFull(txBufFull),
    .txIrq(txIrq), .rxFull(rxFull), .rxIrq(rxIrq), .rxData(rdData),
    .rxParErr(rxParErr), .errSeen(errSeen), .txOut(txOut));

  assign txBufEmpty = ~txBufFull;
  assign txRegEmpty = ~txRun;
endmodule

// File: rtl/sc_halfduplex_uart_chk.sv
module sc_halfduplex_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic txEnable,
  input logic rxEnable,
  input logic rdStrobe,
  input logic txIrqClr,
  input logic txOut,
  input logic txBufEmpty,
  input logic txRegEmpty,
  input logic txIrq,
  input logic rxFull,
  input logic rxIrq
);
  p_quiet_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (txRegEmpty && !rxEnable && !$past(rxEnable)) |-> txOut);

  p_load_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txBufEmpty) |-> !txRegEmpty);

  p_irq_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txIrq) |-> txRegEmpty);

  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (txIrq && !txIrqClr) |=> txIrq);

  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rxFull && !rdStrobe) |=> rxFull);

  p_rxirq_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxIrq) |-> rxFull);

  p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !txEnable |=> txRegEmpty);
endmodule

bind sc_halfduplex_uart sc_halfduplex_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txEnable(txEnable), .rxEnable(rxEnable),
  .rdStrobe(rdStrobe), .txIrqClr(txIrqClr), .txOut(txOut),
  .txBufEmpty(txBufEmpty), .txRegEmpty(txRegEmpty), .txIrq(txIrq),
  .rxFull(rxFull), .rxIrq(rxIrq));

// File: tb/tb_sc_halfduplex_uart.sv
`timescale 1ns/1ps
module tb_sc_halfduplex_uart;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] divVal = 8'd0;
  logic       txEnable = 1'b0, rxEnable = 1'b0, invFormat = 1'b0;
  logic       wrStrobe = 1'b0, rdStrobe = 1'b0, txIrqClr = 1'b0, rxIrqClr = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       cardDrive = 1'b1;
  logic       lineW;
  logic       txOut, txBufEmpty, txRegEmpty, txIrq, rxFull, rxIrq, rxParErr, errSeen;
  int         nChecks = 0, nFails = 0, cycles = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;
  assign lineW = txOut & cardDrive;

  sc_halfduplex_uart dut (
    .clk(clk), .rst_n(rst_n), .divVal(divVal), .txEnable(txEnable),
    .rxEnable(rxEnable), .invFormat(invFormat), .wrStrobe(wrStrobe),
    .wrData(wrData), .rdStrobe(rdStrobe), .rdData(rdData),
    .txIrqClr(txIrqClr), .rxIrqClr(rxIrqClr), .lineIn(lineW), .txOut(txOut),
    .txBufEmpty(txBufEmpty), .txRegEmpty(txRegEmpty), .txIrq(txIrq),
    .rxFull(rxFull), .rxIrq(rxIrq), .rxParErr(rxParErr), .errSeen(errSeen));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic logic [10:0] frameOf(logic [7:0] d, bit inv);
    logic [7:0] lv;
    for (int i = 0; i < 8; i++) lv[i] = inv ? ~d[7-i] : d[i];
    return {1'b1, ^lv, lv, 1'b0};
  endfunction

  function automatic string slotReq(int j);
    if (j == 9) return "R2 parity slot";
    if (j >= 1 && j <= 8) return "R3 data slot";
    return "R1 start/stop slot";
  endfunction

  task automatic pulse_tx_clr();
    txIrqClr = 1'b1; @(negedge clk); txIrqClr = 1'b0;
  endtask

  // Transmit one character; the bench plays the card and may pull the stop slot
  task automatic tx_run(logic [7:0] d, bit inv, int n, bit pull);
    int P = 16 * (n + 1);
    logic [10:0] fr = frameOf(d, inv);
    divVal = 8'(n); invFormat = inv; wrData = d; wrStrobe = 1'b1;
    @(negedge clk); wrStrobe = 1'b0;
    chk("R5 buffer busy after write", txBufEmpty, 0);
    for (int k = 1; k <= 1 + 11 * P; k++) begin
      @(negedge clk);
      if (k == 1) chk("R5 buffer empty after load", txBufEmpty, 1);
      if (k == 2) chk("R9 errSeen cleared at load", errSeen, 0);
      for (int j = 0; j < 11; j++) begin
        if (k == 1 + j * P + P / 2) chk(slotReq(j), txOut, fr[j]);
        if (j < 10 && k == (j + 1) * P) chk("R4 last cycle of slot", txOut, fr[j]);
        if (j < 10 && k == 1 + (j + 1) * P) chk("R4 first cycle of slot", txOut, fr[j+1]);
      end
      if (pull && k == 2 + 10 * P) cardDrive = 1'b0;
      if (k == 11 * P) begin
        cardDrive = 1'b1;
        chk("R6 irq not before stop end", txIrq, 0);
      end
    end
    chk("R6 irq at stop end", txIrq, 1);
    chk("R6 shift register empty", txRegEmpty, 1);
    chk("R9 error echo latched", errSeen, pull);
    @(negedge clk);
    chk("R6 irq held", txIrq, 1);
    pulse_tx_clr();
    chk("R6 irq cleared", txIrq, 0);
  endtask

  // Bench transmits one character toward the receiver
  task automatic rx_run(logic [7:0] d, bit inv, int n, bit badPar);
    int P = 16 * (n + 1);
    logic [10:0] fr = frameOf(d, inv);
    if (badPar) fr[9] = ~fr[9];
    divVal = 8'(n); invFormat = inv;
    for (int j = 0; j < 11; j++) begin
      cardDrive = fr[j];
      for (int t = 0; t < P; t++) begin
        @(negedge clk);
        if (j == 9 && t == P / 2) chk("R8 no echo in parity slot", txOut, 1);
        if (j == 10 && t == P / 2) begin
          chk("R8 echo in stop slot", txOut, !badPar);
          chk("R7 no irq before stop end", rxIrq, 0);
        end
      end
    end
    cardDrive = 1'b1;
    repeat (5) @(negedge clk);
    chk("R7 rxFull set", rxFull, 1);
    chk("R7 rxIrq set", rxIrq, 1);
    chk("R3 decoded byte", rdData, d);
    chk("R8 parity status", rxParErr, badPar);
    chk("R8 line released", txOut, 1);
    rdStrobe = 1'b1; @(negedge clk); rdStrobe = 1'b0;
    chk("R7 read clears full", rxFull, 0);
    chk("R7 read keeps irq", rxIrq, 1);
    rxIrqClr = 1'b1; @(negedge clk); rxIrqClr = 1'b0;
    chk("R7 irq cleared", rxIrq, 0);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset idle line", txOut, 1);
    chk("R5 reset buffer empty", txBufEmpty, 1);
    chk("R6 reset register empty", txRegEmpty, 1);
    chk("R6 reset irq", txIrq, 0);
    chk("R7 reset full", rxFull, 0);
    chk("R7 reset irq", rxIrq, 0);
    chk("R9 reset errSeen", errSeen, 0);

    // Transmit sweep
    txEnable = 1'b1;
    for (int n = 0; n < 2; n++)
      for (int inv = 0; inv < 2; inv++)
        for (int i = 0; i < 10; i++)
          tx_run((i == 0) ? 8'h00 : (i == 9) ? 8'hFF : 8'(i * 53 + 7), inv[0], n, (i % 3) == 0);
    tx_run(8'hA5, 1'b0, 2, 1'b0);

    // R10 transmitter gating and abort
    txEnable = 1'b0;
    divVal = 8'd0; invFormat = 1'b0; wrData = 8'h3C; wrStrobe = 1'b1;
    @(negedge clk); wrStrobe = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 no start while disabled", txOut, 1);
    chk("R10 buffer held while disabled", txBufEmpty, 0);
    chk("R10 register idle while disabled", txRegEmpty, 1);
    txEnable = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10 start after enable", txOut, 0);
    repeat (40) @(negedge clk);
    txEnable = 1'b0;
    @(negedge clk);
    chk("R10 abort releases line", txOut, 1);
    chk("R10 abort empties register", txRegEmpty, 1);
    repeat (200) @(negedge clk);
    chk("R10 no irq after abort", txIrq, 0);
    txEnable = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 nothing resent", txRegEmpty, 1);
    txEnable = 1'b0;

    // Receive sweep
    rxEnable = 1'b1;
    for (int n = 0; n < 2; n++)
      for (int inv = 0; inv < 2; inv++)
        for (int i = 0; i < 10; i++)
          rx_run((i == 0) ? 8'h00 : (i == 9) ? 8'hFF : 8'(i * 29 + 3), inv[0], n, (i % 4) == 1);
    rx_run(8'h5A, 1'b1, 2, 1'b1);

    // R11 short glitch on idle line
    divVal = 8'd1;
    cardDrive = 1'b0; repeat (3) @(negedge clk); cardDrive = 1'b1;
    repeat (60) @(negedge clk);
    chk("R11 glitch ignored", rxFull, 0);
    chk("R11 glitch no irq", rxIrq, 0);
    rx_run(8'hC3, 1'b0, 1, 1'b0);

    // R10 receiver disabled, then aborted mid-character
    rxEnable = 1'b0;
    divVal = 8'd0;
    for (int j = 0; j < 11; j++) begin
      cardDrive = frameOf(8'h81, 1'b0) >> j;
      repeat (16) @(negedge clk);
    end
    cardDrive = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 disabled receiver ignores line", rxFull, 0);
    rxEnable = 1'b1;
    for (int j = 0; j < 11; j++) begin
      cardDrive = frameOf(8'h42, 1'b0) >> j;
      if (j == 5) rxEnable = 1'b0;
      repeat (16) @(negedge clk);
    end
    cardDrive = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10 aborted character discarded", rxFull, 0);
    chk("R10 aborted character no irq", rxIrq, 0);
    rxEnable = 1'b1;
    repeat (4) @(negedge clk);
    rx_run(8'h42, 1'b0, 0, 1'b0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule